// File: doc/BRIEF.md
# Flash segment window decoder

This block owns the map of a fixed flash address window onto a set of chip selects. Each chip select has one segment register giving the start and end of its region in 8 MB units. A register bus writes and reads those registers. Every write is checked before it is committed: writes that would leave the window are refused, and misaligned or overlapping segments are accepted but reported. The result of each write shows for exactly one cycle on a set of flag outputs.

Two lookup ports use the live map. The decode port takes an absolute window address and returns the chip select that owns it, a hit flag and the offset inside that segment. The local port takes a chip select and a local offset and returns the offset folded into the segment size, with a flag when folding was needed. Both ports are registered, so results appear one clock after the inputs.

Top module: `flash_seg_map`

## Requirements
- R1: After reset the segment registers read 0x48400000, 0x4C480000, 0x504C0000, 0x54500000 and 0x58540000 for chip selects 0 to 4. The register word holds the end in bits [31:24] and the start in bits [23:16], both as byte address shifted right by 23. All flag outputs are 0.
- R2: An accepted write is visible on rd_data on the cycle after the write, with bits [15:0] always read as zero.
- R3: A write to chip select 0 always stores a start of 0x40 (window base 0x20000000), whatever start field was written.
- R4: A write whose end field is at or below 0x40, or whose start field is above 0x60 (window top 0x30000000 in units), is discarded: the register keeps its old value and wr_done and wr_reject both pulse.
- R5: An accepted write whose start is not a multiple of its size (end minus start, power of two) is stored and raises wr_misalign.
- R6: An accepted write whose new range satisfies start_new < end_other and end_new > start_other for any other chip select is stored and raises wr_overlap.
- R7: A write of the exact 32-bit word already held changes nothing and raises no flag, not even wr_done.
- R8: The decode port reports a hit for the lowest-numbered chip select whose range covers the address, with offset equal to address minus segment start; with no hit it reports chip select 0 and offset 0. Results follow the address by one cycle.
- R9: A segment whose end is not above its start never hits on the decode port, and the local port reports it invalid with a folded offset of 0.
- R10: On the local port an offset below the segment size is returned unchanged with the invalid flag clear; an offset at or above the size, or a chip select index of 5 or more, returns the offset masked by size minus one (0 for a bad index) with the invalid flag set, one cycle later.
- R11: Write flags are single-cycle pulses, valid in the cycle right after the write and low in the next cycle unless another write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Segment register write strobe |
| wr_sel | input | 3 | Chip select whose register is written |
| wr_data | input | 32 | Write word: end [31:24], start [23:16] |
| rd_sel | input | 3 | Chip select whose register is read |
| rd_data | output | 32 | Read word of the selected register, 0 for a bad index |
| wr_done | output | 1 | A non-identical write to a valid index was processed |
| wr_reject | output | 1 | The processed write was discarded |
| wr_misalign | output | 1 | The accepted write has a misaligned start |
| wr_overlap | output | 1 | The accepted write overlaps another segment |
| dec_addr | input | 32 | Absolute window address to decode |
| dec_hit | output | 1 | Address falls in some segment |
| dec_cs | output | 3 | Owning chip select |
| dec_offset | output | 32 | Offset inside the owning segment |
| loc_cs | input | 3 | Chip select for a local access |
| loc_offset | input | 32 | Local offset to check |
| loc_wrapped | output | 32 | Offset folded into the segment size |
| loc_invalid | output | 1 | Offset or index was out of range |

## Verification
A corrupted segment register shows up at once on rd_data and, one cycle later, as a wrong chip select or offset on the decode port for any address near that segment's bounds. A wrong validation decision shows in the flag pulse of the same write and in the read-back of the register right after it. Faults in the size calculation surface on the local port as a wrong folded offset or invalid flag one cycle after the offset is applied, and are checked at the exact size boundary.

// File: rtl/flash_seg_pkg.sv
`timescale 1ns/1ps
package flash_seg_pkg;

  localparam int UNIT_SHIFT = 23;
  localparam int UNIT_W     = 8;

  typedef logic [UNIT_W-1:0] unit_t;

  typedef struct packed {
    unit_t end_u;
    unit_t start_u;
  } seg_t;

  function automatic logic [31:0] seg_to_word(input seg_t s);
    return {s.end_u, s.start_u, 16'h0000};
  endfunction

  // size in units; an end not above the start means an empty segment
  function automatic unit_t seg_size(input seg_t s);
    return (s.end_u > s.start_u) ? unit_t'(s.end_u - s.start_u) : '0;
  endfunction

endpackage

// File: rtl/flash_seg_regs.sv
`timescale 1ns/1ps
module flash_seg_regs
  import flash_seg_pkg::*;
#(
  parameter int    NUM_CS   = 5,
  parameter int    CS_W     = 3,
  parameter unit_t BASE_U   = 8'h40,
  parameter unit_t TOP_U    = 8'h60,
  parameter unit_t CS0_SZ_U = 8'h08,
  parameter unit_t CSN_SZ_U = 8'h04
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CS_W-1:0]        wr_sel,
  input  logic [31:0]            wr_data,
  output seg_t [NUM_CS-1:0]      seg_o,
  output logic                   wr_done,
  output logic                   wr_reject,
  output logic                   wr_misalign,
  output logic                   wr_overlap
);

  function automatic seg_t dflt(input int idx);
    seg_t s;
    int   st;
    int   sz;
    st = (idx == 0) ? int'(BASE_U)
                    : int'(BASE_U) + int'(CS0_SZ_U) + (idx - 1) * int'(CSN_SZ_U);
    sz = (idx == 0) ? int'(CS0_SZ_U) : int'(CSN_SZ_U);
    s.start_u = unit_t'(st);
    s.end_u   = unit_t'(st + sz);
    return s;
  endfunction

  seg_t [NUM_CS-1:0] seg_q, seg_d;
  logic              seg_en;
  logic              done_d, reject_d, misal_d, ovl_d;
  logic              done_q, reject_q, misal_q, ovl_q;

  seg_t              cur_seg, new_seg;
  logic              sel_ok, sel_zero, same_val, active, bad_range, misal, ovl;
  unit_t             new_sz;

  // write validation
  always_comb begin
    cur_seg = '0;
    sel_ok  = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (wr_sel == CS_W'(i)) begin
        cur_seg = seg_q[i];
        sel_ok  = 1'b1;
      end
    end
    sel_zero        = (wr_sel == '0);
    new_seg.end_u   = wr_data[31:24];
    new_seg.start_u = sel_zero ? BASE_U : wr_data[23:16];
    same_val        = (wr_data == seg_to_word(cur_seg));
    active          = wr_en && sel_ok && !same_val;
    bad_range       = (new_seg.end_u <= BASE_U) || (new_seg.start_u > TOP_U);
    new_sz          = seg_size(new_seg);
    misal           = (new_sz != '0) &&
                      ((new_seg.start_u & unit_t'(new_sz - 8'd1)) != '0);
    ovl = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if ((wr_sel != CS_W'(i)) &&
          (new_seg.start_u < seg_q[i].end_u) &&
          (new_seg.end_u > seg_q[i].start_u)) begin
        ovl = 1'b1;
      end
    end
  end

  // next state
  always_comb begin
    seg_en = active && !bad_range;
    seg_d  = seg_q;
    for (int i = 0; i < NUM_CS; i++) begin
      if (seg_en && (wr_sel == CS_W'(i))) begin
        seg_d[i] = new_seg;
      end
    end
    done_d   = active;
    reject_d = active && bad_range;
    misal_d  = seg_en && misal;
    ovl_d    = seg_en && ovl;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        seg_q[i] <= dflt(i);
      end
    end else if (seg_en) begin
      seg_q <= seg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      reject_q <= 1'b0;
      misal_q  <= 1'b0;
      ovl_q    <= 1'b0;
    end else begin
      done_q   <= done_d;
      reject_q <= reject_d;
      misal_q  <= misal_d;
      ovl_q    <= ovl_d;
    end
  end

  assign seg_o       = seg_q;
  assign wr_done     = done_q;
  assign wr_reject   = reject_q;
  assign wr_misalign = misal_q;
  assign wr_overlap  = ovl_q;

endmodule

// File: rtl/flash_seg_decode.sv
`timescale 1ns/1ps
module flash_seg_decode
  import flash_seg_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int CS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seg_t [NUM_CS-1:0] seg_i,
  input  logic [31:0]       addr,
  output logic              hit,
  output logic [CS_W-1:0]   cs,
  output logic [31:0]       offset
);

  logic [8:0]        addr_u;
  logic [NUM_CS-1:0] hit_vec;
  logic              hit_d, hit_q;
  logic [CS_W-1:0]   cs_d, cs_q;
  logic [31:0]       off_d, off_q;

  assign addr_u = addr[31:23];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    assign hit_vec[g] = (seg_size(seg_i[g]) != '0) &&
                        ({1'b0, seg_i[g].start_u} <= addr_u) &&
                        (addr_u < {1'b0, seg_i[g].end_u});
  end

  // lowest index wins: scan downward so the last match kept is the lowest
  always_comb begin
    hit_d = 1'b0;
    cs_d  = '0;
    off_d = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_d = 1'b1;
        cs_d  = CS_W'(i);
        off_d = addr - {1'b0, seg_i[i].start_u, 23'h0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      cs_q  <= '0;
      off_q <= '0;
    end else begin
      hit_q <= hit_d;
      cs_q  <= cs_d;
      off_q <= off_d;
    end
  end

  assign hit    = hit_q;
  assign cs     = cs_q;
  assign offset = off_q;

endmodule

// File: rtl/flash_seg_wrap.sv
`timescale 1ns/1ps
module flash_seg_wrap
  import flash_seg_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int CS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seg_t [NUM_CS-1:0] seg_i,
  input  logic [CS_W-1:0]   loc_cs,
  input  logic [31:0]       loc_offset,
  output logic [31:0]       loc_wrapped,
  output logic              loc_invalid
);

  unit_t       sz_u;
  logic [31:0] sz_b;
  logic [31:0] wrap_d, wrap_q;
  logic        inv_d, inv_q;

  always_comb begin
    sz_u = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (loc_cs == CS_W'(i)) begin
        sz_u = seg_size(seg_i[i]);
      end
    end
    sz_b = {1'b0, sz_u, 23'h0};
    if (sz_u == '0) begin
      inv_d  = 1'b1;
      wrap_d = '0;
    end else begin
      inv_d  = (loc_offset >= sz_b);
      wrap_d = loc_offset & (sz_b - 32'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q <= '0;
      inv_q  <= 1'b1;
    end else begin
      wrap_q <= wrap_d;
      inv_q  <= inv_d;
    end
  end

  assign loc_wrapped = wrap_q;
  assign loc_invalid = inv_q;

endmodule

// File: rtl/flash_seg_map.sv
`timescale 1ns/1ps
module flash_seg_map
  import flash_seg_pkg::*;
#(
  parameter int          NUM_CS   = 5,
  parameter logic [31:0] WIN_BASE = 32'h2000_0000,
  parameter logic [31:0] WIN_SIZE = 32'h1000_0000,
  parameter logic [31:0] CS0_SIZE = 32'h0400_0000,
  parameter logic [31:0] CSN_SIZE = 32'h0200_0000,
  localparam int         CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CS_W-1:0] wr_sel,
  input  logic [31:0]     wr_data,
  input  logic [CS_W-1:0] rd_sel,
  output logic [31:0]     rd_data,
  output logic            wr_done,
  output logic            wr_reject,
  output logic            wr_misalign,
  output logic            wr_overlap,
  input  logic [31:0]     dec_addr,
  output logic            dec_hit,
  output logic [CS_W-1:0] dec_cs,
  output logic [31:0]     dec_offset,
  input  logic [CS_W-1:0] loc_cs,
  input  logic [31:0]     loc_offset,
  output logic [31:0]     loc_wrapped,
  output logic            loc_invalid
);

  localparam unit_t BASE_U   = unit_t'(WIN_BASE >> UNIT_SHIFT);
  localparam unit_t TOP_U    = unit_t'((WIN_BASE + WIN_SIZE) >> UNIT_SHIFT);
  localparam unit_t CS0_SZ_U = unit_t'(CS0_SIZE >> UNIT_SHIFT);
  localparam unit_t CSN_SZ_U = unit_t'(CSN_SIZE >> UNIT_SHIFT);

  seg_t [NUM_CS-1:0] seg_map;

  flash_seg_regs #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .BASE_U(BASE_U), .TOP_U(TOP_U),
    .CS0_SZ_U(CS0_SZ_U), .CSN_SZ_U(CSN_SZ_U)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .seg_o(seg_map), .wr_done(wr_done),
    .wr_reject(wr_reject), .wr_misalign(wr_misalign), .wr_overlap(wr_overlap)
  );

  flash_seg_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .seg_i(seg_map), .addr(dec_addr),
    .hit(dec_hit), .cs(dec_cs), .offset(dec_offset)
  );

  flash_seg_wrap #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_wrap (
    .clk(clk), .rst_n(rst_n), .seg_i(seg_map), .loc_cs(loc_cs),
    .loc_offset(loc_offset), .loc_wrapped(loc_wrapped),
    .loc_invalid(loc_invalid)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (rd_sel == CS_W'(i)) begin
        rd_data = seg_to_word(seg_map[i]);
      end
    end
  end

endmodule

// File: rtl/flash_seg_map_chk.sv
`timescale 1ns/1ps
module flash_seg_map_chk #(
  parameter int         NUM_CS = 5,
  parameter int         CS_W   = 3,
  parameter logic [7:0] BASE_U = 8'h40
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [CS_W-1:0]       wr_sel,
  input logic [31:0]           wr_data,
  input logic [16*NUM_CS-1:0]  seg_flat,
  input logic [31:0]           rd_data,
  input logic                  wr_done,
  input logic                  wr_reject,
  input logic                  wr_misalign,
  input logic                  wr_overlap,
  input logic                  dec_hit,
  input logic [CS_W-1:0]       dec_cs,
  input logic [31:0]           dec_offset,
  input logic [31:0]           loc_offset,
  input logic [31:0]           loc_wrapped,
  input logic                  loc_invalid
);

  logic [31:0] held_word;

  always_comb begin
    held_word = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (wr_sel == CS_W'(i)) begin
        held_word = {seg_flat[16*i+8 +: 8], seg_flat[16*i +: 8], 16'h0000};
      end
    end
  end

  assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15:0] == 16'h0000);

  assert_cs0_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_flat[7:0] == BASE_U);

  assert_reject_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $stable(seg_flat));

  assert_same_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data == held_word)) |=> (!wr_done && $stable(seg_flat)));

  assert_dec_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> ({1'b0, dec_cs} < (CS_W+1)'(NUM_CS)));

  assert_dec_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> (dec_cs == '0 && dec_offset == 32'h0));

  assert_loc_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_invalid |-> (loc_wrapped == $past(loc_offset)));

  assert_flag_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reject || wr_misalign || wr_overlap) |-> wr_done);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !$past(wr_en)) |-> 1'b0);

endmodule

bind flash_seg_map flash_seg_map_chk #(
  .NUM_CS(NUM_CS), .CS_W(CS_W), .BASE_U(BASE_U)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .seg_flat(seg_map), .rd_data(rd_data),
  .wr_done(wr_done), .wr_reject(wr_reject), .wr_misalign(wr_misalign),
  .wr_overlap(wr_overlap), .dec_hit(dec_hit), .dec_cs(dec_cs),
  .dec_offset(dec_offset), .loc_offset(loc_offset),
  .loc_wrapped(loc_wrapped), .loc_invalid(loc_invalid)
);

// File: tb/flash_seg_map_bench.sv
`timescale 1ns/1ps
module flash_seg_map_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic [2:0]  rd_sel;
  logic [31:0] rd_data;
  logic        wr_done, wr_reject, wr_misalign, wr_overlap;
  logic [31:0] dec_addr;
  logic        dec_hit;
  logic [2:0]  dec_cs;
  logic [31:0] dec_offset;
  logic [2:0]  loc_cs;
  logic [31:0] loc_offset;
  logic [31:0] loc_wrapped;
  logic        loc_invalid;

  int n_chk = 0;
  int n_err = 0;
  logic finished = 1'b0;

  flash_seg_map u_flash_seg_map (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_done(wr_done), .wr_reject(wr_reject), .wr_misalign(wr_misalign),
    .wr_overlap(wr_overlap), .dec_addr(dec_addr), .dec_hit(dec_hit),
    .dec_cs(dec_cs), .dec_offset(dec_offset), .loc_cs(loc_cs),
    .loc_offset(loc_offset), .loc_wrapped(loc_wrapped),
    .loc_invalid(loc_invalid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {addr, hit, cs, offset}
  localparam logic [67:0] DEC_VEC [8] = '{
    {32'h2000_0000, 1'b1, 3'd0, 32'h0000_0000},
    {32'h23FF_FFFC, 1'b1, 3'd0, 32'h03FF_FFFC},
    {32'h2400_0010, 1'b1, 3'd1, 32'h0000_0010},
    {32'h2600_0000, 1'b1, 3'd2, 32'h0000_0000},
    {32'h2800_0004, 1'b1, 3'd3, 32'h0000_0004},
    {32'h2BFF_FFFF, 1'b1, 3'd4, 32'h01FF_FFFF},
    {32'h2C00_0000, 1'b0, 3'd0, 32'h0000_0000},
    {32'h1FFF_FFFF, 1'b0, 3'd0, 32'h0000_0000}
  };

  // {cs, offset, wrapped, invalid}
  localparam logic [67:0] LOC_VEC [6] = '{
    {3'd0, 32'h0000_0100, 32'h0000_0100, 1'b0},
    {3'd0, 32'h0400_0000, 32'h0000_0000, 1'b1},
    {3'd1, 32'h0200_0005, 32'h0000_0005, 1'b1},
    {3'd2, 32'h01FF_FFFF, 32'h01FF_FFFF, 1'b0},
    {3'd4, 32'hFFFF_FFFF, 32'h01FF_FFFF, 1'b1},
    {3'd5, 32'h0000_0007, 32'h0000_0000, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic check_flags(input string tag, input logic [3:0] exp);
    check(tag, {28'h0, wr_done, wr_reject, wr_misalign, wr_overlap},
          {28'h0, exp});
  endtask

  task automatic check_reg(input string tag, input logic [2:0] sel,
                           input logic [31:0] exp);
    rd_sel = sel;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic check_dec(input string tag, input logic [31:0] a,
                           input logic h, input logic [2:0] c,
                           input logic [31:0] off);
    @(negedge clk);
    dec_addr = a;
    @(negedge clk);
    check(tag, {28'h0, dec_hit, dec_cs}, {28'h0, h, c});
    check(tag, dec_offset, off);
  endtask

  task automatic check_loc(input string tag, input logic [2:0] c,
                           input logic [31:0] off, input logic [31:0] w,
                           input logic inv);
    @(negedge clk);
    loc_cs     = c;
    loc_offset = off;
    @(negedge clk);
    check(tag, loc_wrapped, w);
    check(tag, {31'h0, loc_invalid}, {31'h0, inv});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    wr_en      = 1'b0;
    wr_sel     = '0;
    wr_data    = '0;
    rd_sel     = '0;
    dec_addr   = '0;
    loc_cs     = '0;
    loc_offset = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_flags("R1 flags", 4'b0000);
    check_reg("R1 cs0", 3'd0, 32'h4840_0000);
    check_reg("R1 cs1", 3'd1, 32'h4C48_0000);
    check_reg("R1 cs2", 3'd2, 32'h504C_0000);
    check_reg("R1 cs3", 3'd3, 32'h5450_0000);
    check_reg("R1 cs4", 3'd4, 32'h5854_0000);

    // R8 decode table on the reset map
    for (int i = 0; i < 8; i++) begin
      check_dec("R8 table", DEC_VEC[i][67:36], DEC_VEC[i][35],
                DEC_VEC[i][34:32], DEC_VEC[i][31:0]);
    end

    // R10 local wrap table on the reset map
    for (int i = 0; i < 6; i++) begin
      check_loc("R10 table", LOC_VEC[i][67:65], LOC_VEC[i][64:33],
                LOC_VEC[i][32:1], LOC_VEC[i][0]);
    end

    // R4 end below window base
    do_write(3'd1, 32'h3028_0000);
    check_flags("R4 low end flags", 4'b1100);
    check_reg("R4 low end hold", 3'd1, 32'h4C48_0000);
    @(negedge clk);
    check_flags("R11 pulse ends", 4'b0000);

    // R4 start above window top
    do_write(3'd2, 32'h7061_0000);
    check_flags("R4 high start flags", 4'b1100);
    check_reg("R4 high start hold", 3'd2, 32'h504C_0000);

    // R4 start exactly at window top is accepted
    do_write(3'd2, 32'h6460_0000);
    check_flags("R4 top boundary flags", 4'b1000);
    check_reg("R2 top boundary read", 3'd2, 32'h6460_0000);

    // R5 misaligned start
    do_write(3'd3, 32'h5E5A_0000);
    check_flags("R5 misalign flags", 4'b1010);
    check_reg("R5 misalign stored", 3'd3, 32'h5E5A_0000);

    // R6 overlap with cs1
    do_write(3'd4, 32'h4C48_0000);
    check_flags("R6 overlap flags", 4'b1001);
    check_reg("R6 overlap stored", 3'd4, 32'h4C48_0000);
    check_dec("R8 lowest index", 32'h2400_0000, 1'b1, 3'd1, 32'h0);
    check_dec("R8 vacated miss", 32'h2A00_0000, 1'b0, 3'd0, 32'h0);

    // R3 cs0 start locked
    do_write(3'd0, 32'h5010_0000);
    check_flags("R3 cs0 flags", 4'b1001);
    check_reg("R3 cs0 start forced", 3'd0, 32'h5040_0000);
    check_dec("R8 grown cs0 wins", 32'h2400_0000, 1'b1, 3'd0, 32'h0400_0000);
    check_loc("R10 cs0 wrap", 3'd0, 32'h0800_0004, 32'h0000_0004, 1'b1);

    // R7 identical write
    do_write(3'd2, 32'h6460_0000);
    check_flags("R7 same flags", 4'b0000);
    check_reg("R7 same hold", 3'd2, 32'h6460_0000);

    // R2 low bits dropped
    do_write(3'd2, 32'h6860_ABCD);
    check_flags("R2 low bits flags", 4'b1000);
    check_reg("R2 low bits zero", 3'd2, 32'h6860_0000);

    // R9 empty segment
    do_write(3'd3, 32'h5858_0000);
    check_flags("R9 empty flags", 4'b1000);
    check_reg("R9 empty stored", 3'd3, 32'h5858_0000);
    check_dec("R9 empty no hit", 32'h2C00_0000, 1'b0, 3'd0, 32'h0);
    check_loc("R9 empty local", 3'd3, 32'h0000_0000, 32'h0, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule